// File: doc/BRIEF.md
# Shared-period multi-channel PWM generator

This block drives a small set of PWM outputs from one free-running 16-bit tick counter. Each channel slot has its own pulse compare value. A single extra compare value sets the period, and every channel shares it. The outputs are not produced by magnitude comparators. A slot output flips when the counter reaches that slot's pulse value. When the counter reaches the period value, every active slot output flips and the counter returns to zero.

Software or a sequencer sends configuration requests of the form (output id, period, pulse, flags). The block validates each request and binds the output id to a slot. It then programs the compare values and starts or stops the shared counter. A pulse of zero gives a static low level and a pulse equal to the period gives a static high level. Neither of these uses the counter. The tick rate is the input clock divided by 2 raised to `prescSel`.

Top module: `pwm_share_top`

## Requirements
- R1: A request with nonzero `reqFlags` completes with status 3 (unsupported) and changes no slot binding, output level or run state.
- R2: A request whose period exceeds 65535 completes with status 1, whatever its pulse value.
- R3: A request with pulse strictly between 0 and the period completes with status 1 if the period differs from the stored common period and any slot bound to a different id is active. A request from the id that is already active may change the period. Static requests (pulse 0 or pulse equal to the period) never fail this check.
- R4: Slot selection first reuses the lowest slot already bound to the requested id. Otherwise it takes the highest-indexed inactive slot. If neither exists, the request completes with status 2. On success, `doneSlot` reports the chosen slot.
- R5: An accepted request with pulse strictly between 0 and the period performs four actions: it marks the slot active, drives its output high, clears the counter, and sets `cntRunning`.
- R6: After such a start, the slot output stays high for `pulse` ticks of every `period` ticks. It falls on the pulse match and rises on the period match, where the counter also wraps to 0.
- R7: An accepted request with pulse 0 drives the slot output low. One with pulse equal to the period drives it high. In both cases the slot is marked inactive and the level is held.
- R8: When a static request leaves no slot active, `cntRunning` drops. While the counter is stopped and no request arrives, all outputs hold their levels.
- R9: One counter tick occurs every 2^`prescSel` clock cycles. The tick divider restarts on each toggling start, so the high time is `pulse`·2^`prescSel` clock cycles.
- R10: Every request cycle produces `doneValid` high in exactly the next cycle, together with a status. The status codes are 0 = accepted, 1 = bad period, 2 = no slot, 3 = unsupported flags. A rejected request leaves all state unchanged.
- R11: After reset, all outputs are low, `cntRunning` is low, no slot is bound or active, and `doneValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the tick reference |
| rstN | input | 1 | Active-low synchronous reset |
| prescSel | input | PS_W | Tick divider exponent |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqId | input | ID_W | Output id to configure |
| reqPeriod | input | REQ_W | Requested period in ticks |
| reqPulse | input | REQ_W | Requested high time in ticks |
| reqFlags | input | FLAG_W | Polarity flags, only zero is supported |
| doneValid | output | 1 | Request completion pulse |
| doneStatus | output | 2 | Completion status code |
| doneSlot | output | SIW | Slot bound by an accepted request |
| pwmOut | output | NUM_CH | One PWM level per slot |
| cntRunning | output | 1 | Shared counter is running |
| boundIds | output | NUM_CH*ID_W | Output id bound to each slot, slot 0 in the low bits |

## Verification
The checker enforces five properties on every cycle. Completion follows each request cycle exactly once. Flag and range rejections produce the right code and leave the bindings and run state untouched. An accepted toggling start comes up running with its output high, and a zero-pulse start comes up low. A stopped counter freezes every output. Only the bench scenarios can show the things that span many cycles or depend on history. These include the high-time fraction across periods and prescaler settings, the choice between reusing a bound slot and taking the highest free one, the period-clash rule among several ids, and the counter stopping when the last active slot goes static.

// File: rtl/pwm_share_pkg.sv
package pwm_share_pkg;
  // Widest slot index carried between control and datapath (up to 16 slots).
  localparam int SLOT_W = 4;

  typedef enum logic [1:0] {
    ST_OK         = 2'd0,
    ST_BAD_PERIOD = 2'd1,
    ST_NO_SLOT    = 2'd2,
    ST_BAD_FLAGS  = 2'd3
  } status_e;

  // Strobes from control to datapath, valid in the request cycle.
  typedef struct packed {
    logic              apply;     // request accepted, update slot
    logic              toggling;  // duty strictly between 0% and 100%
    logic              level;     // static level when not toggling
    logic              stop;      // no active slot remains after this request
    logic [SLOT_W-1:0] slot;      // slot being written
  } strobe_t;
endpackage

// File: rtl/pwm_share_tick.sv
module pwm_share_tick #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            run,
  input  logic            restart,
  input  logic [PS_W-1:0] prescSel,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLimit;

  assign divLimit = DIV_W'((32'd1 << prescSel) - 32'd1);
  assign tick     = run && (divCnt == divLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (restart) begin
      divCnt <= '0;
    end else if (run) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_share_ctrl.sv
module pwm_share_ctrl
  import pwm_share_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ID_W   = 5,
  parameter int REQ_W  = 20,
  parameter int CNT_W  = 16,
  parameter int FLAG_W = 2,
  parameter int SIW    = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [ID_W-1:0]        reqId,
  input  logic [REQ_W-1:0]       reqPeriod,
  input  logic [REQ_W-1:0]       reqPulse,
  input  logic [FLAG_W-1:0]      reqFlags,
  input  logic [NUM_CH*ID_W-1:0] slotIds,
  input  logic [NUM_CH-1:0]      slotBound,
  input  logic [NUM_CH-1:0]      slotActive,
  input  logic [CNT_W-1:0]       periodReg,
  output strobe_t                strobes,
  output logic                   doneValid,
  output logic [1:0]             doneStatus,
  output logic [SIW-1:0]         doneSlot
);
  logic [NUM_CH-1:0] idMatch;
  logic              isStatic, tooLong, clash;
  logic              matchFound, freeFound;
  logic [SIW-1:0]    matchIdx, freeIdx, pickIdx;
  logic [NUM_CH-1:0] pickMask;
  status_e           status;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_match
    assign idMatch[i] = slotBound[i] && (slotIds[i*ID_W +: ID_W] == reqId);
  end

  assign isStatic = (reqPulse == '0) || (reqPulse == reqPeriod);
  assign tooLong  = |reqPeriod[REQ_W-1:CNT_W];
  assign clash    = !isStatic && (|(slotActive & ~idMatch)) &&
                    (reqPeriod != REQ_W'(periodReg));

  // Lowest bound slot with the same id; highest inactive slot otherwise.
  always_comb begin
    matchFound = 1'b0;
    matchIdx   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (idMatch[i]) begin
        matchFound = 1'b1;
        matchIdx   = SIW'(i);
      end
    end
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!slotActive[i]) begin
        freeFound = 1'b1;
        freeIdx   = SIW'(i);
      end
    end
  end

  assign pickIdx  = matchFound ? matchIdx : freeIdx;
  assign pickMask = NUM_CH'(1) << pickIdx;

  always_comb begin
    if (reqFlags != '0)                 status = ST_BAD_FLAGS;
    else if (clash || tooLong)          status = ST_BAD_PERIOD;
    else if (!matchFound && !freeFound) status = ST_NO_SLOT;
    else                                status = ST_OK;
  end

  always_comb begin
    strobes          = '0;
    strobes.apply    = reqValid && (status == ST_OK);
    strobes.toggling = !isStatic;
    strobes.level    = (reqPulse != '0);
    strobes.stop     = isStatic && !(|(slotActive & ~pickMask));
    strobes.slot     = SLOT_W'(pickIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid  <= 1'b0;
      doneStatus <= 2'd0;
      doneSlot   <= '0;
    end else begin
      doneValid  <= reqValid;
      doneStatus <= status;
      doneSlot   <= (reqValid && status == ST_OK) ? pickIdx : '0;
    end
  end
endmodule

// File: rtl/pwm_share_dp.sv
module pwm_share_dp
  import pwm_share_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ID_W   = 5,
  parameter int CNT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strobes,
  input  logic [ID_W-1:0]        reqId,
  input  logic [CNT_W-1:0]       reqPeriod,
  input  logic [CNT_W-1:0]       reqPulse,
  input  logic                   tick,
  output logic                   restart,
  output logic                   running,
  output logic [NUM_CH-1:0]      slotActive,
  output logic [NUM_CH-1:0]      slotBound,
  output logic [NUM_CH*ID_W-1:0] slotIds,
  output logic [CNT_W-1:0]       periodReg,
  output logic [NUM_CH-1:0]      pwmOut
);
  logic [CNT_W-1:0] cnt, nextVal;
  logic             wrapEvt, step;

  assign restart = strobes.apply && strobes.toggling;
  assign step    = tick && !restart;
  assign nextVal = cnt + 1'b1;
  assign wrapEvt = (nextVal == periodReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      running   <= 1'b0;
      periodReg <= '0;
    end else if (restart) begin
      cnt       <= '0;
      running   <= 1'b1;
      periodReg <= reqPeriod;
    end else begin
      if (strobes.apply && strobes.stop) running <= 1'b0;
      if (step) cnt <= wrapEvt ? '0 : nextVal;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
    logic [CNT_W-1:0] pulseReg;
    logic [ID_W-1:0]  idReg;
    logic             activeReg, boundReg, outReg, hit;

    assign hit = strobes.apply && (strobes.slot == SLOT_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pulseReg  <= '0;
        idReg     <= '0;
        activeReg <= 1'b0;
        boundReg  <= 1'b0;
        outReg    <= 1'b0;
      end else if (hit) begin
        boundReg  <= 1'b1;
        idReg     <= reqId;
        activeReg <= strobes.toggling;
        pulseReg  <= strobes.toggling ? reqPulse : '0;
        outReg    <= strobes.toggling ? 1'b1 : strobes.level;
      end else if (step && activeReg) begin
        outReg <= outReg ^ (nextVal == pulseReg) ^ wrapEvt;
      end
    end

    assign slotActive[i]               = activeReg;
    assign slotBound[i]                = boundReg;
    assign slotIds[i*ID_W +: ID_W]     = idReg;
    assign pwmOut[i]                   = outReg;
  end
endmodule

// File: rtl/pwm_share_top.sv
module pwm_share_top
  import pwm_share_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ID_W   = 5,
  parameter int REQ_W  = 20,
  parameter int CNT_W  = 16,
  parameter int FLAG_W = 2,
  parameter int PS_W   = 3,
  localparam int SIW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [PS_W-1:0]        prescSel,
  input  logic                   reqValid,
  input  logic [ID_W-1:0]        reqId,
  input  logic [REQ_W-1:0]       reqPeriod,
  input  logic [REQ_W-1:0]       reqPulse,
  input  logic [FLAG_W-1:0]      reqFlags,
  output logic                   doneValid,
  output logic [1:0]             doneStatus,
  output logic [SIW-1:0]         doneSlot,
  output logic [NUM_CH-1:0]      pwmOut,
  output logic                   cntRunning,
  output logic [NUM_CH*ID_W-1:0] boundIds
);
  strobe_t           strobes;
  logic [NUM_CH-1:0] slotActive, slotBound;
  logic [CNT_W-1:0]  periodReg;
  logic              tick, restart;

  pwm_share_ctrl #(
    .NUM_CH(NUM_CH), .ID_W(ID_W), .REQ_W(REQ_W),
    .CNT_W(CNT_W), .FLAG_W(FLAG_W), .SIW(SIW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqId(reqId),
    .reqPeriod(reqPeriod), .reqPulse(reqPulse), .reqFlags(reqFlags),
    .slotIds(boundIds), .slotBound(slotBound), .slotActive(slotActive),
    .periodReg(periodReg), .strobes(strobes), .doneValid(doneValid),
    .doneStatus(doneStatus), .doneSlot(doneSlot)
  );

  pwm_share_dp #(
    .NUM_CH(NUM_CH), .ID_W(ID_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqId(reqId),
    .reqPeriod(reqPeriod[CNT_W-1:0]), .reqPulse(reqPulse[CNT_W-1:0]),
    .tick(tick), .restart(restart), .running(cntRunning),
    .slotActive(slotActive), .slotBound(slotBound), .slotIds(boundIds),
    .periodReg(periodReg), .pwmOut(pwmOut)
  );

  pwm_share_tick #(.PS_W(PS_W)) u_tick (
    .clk(clk), .rstN(rstN), .run(cntRunning), .restart(restart),
    .prescSel(prescSel), .tick(tick)
  );
endmodule

// File: rtl/pwm_share_chk.sv
module pwm_share_chk #(
  parameter int NUM_CH = 3,
  parameter int ID_W   = 5,
  parameter int REQ_W  = 20,
  parameter int CNT_W  = 16,
  parameter int FLAG_W = 2,
  parameter int PS_W   = 3,
  parameter int SIW    = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [PS_W-1:0]        prescSel,
  input logic                   reqValid,
  input logic [ID_W-1:0]        reqId,
  input logic [REQ_W-1:0]       reqPeriod,
  input logic [REQ_W-1:0]       reqPulse,
  input logic [FLAG_W-1:0]      reqFlags,
  input logic                   doneValid,
  input logic [1:0]             doneStatus,
  input logic [SIW-1:0]         doneSlot,
  input logic [NUM_CH-1:0]      pwmOut,
  input logic                   cntRunning,
  input logic [NUM_CH*ID_W-1:0] boundIds
);
  localparam logic [REQ_W-1:0] MAX_PERIOD = REQ_W'((1 << CNT_W) - 1);

  logic periodOk;
  assign periodOk = (reqPeriod <= MAX_PERIOD);

  assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> doneValid);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !doneValid);

  assert_flags_code_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (reqFlags != '0) |=> doneStatus == 2'd3);

  assert_flags_nochange_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (reqFlags != '0) |=> $stable(boundIds) && (cntRunning == $past(cntRunning)));

  assert_long_period_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (reqFlags == '0) && !periodOk |=> doneStatus == 2'd1);

  assert_toggle_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (reqFlags == '0) && periodOk && (reqPulse != '0) && (reqPulse != reqPeriod)
      |=> (doneStatus != 2'd0) || (cntRunning && pwmOut[doneSlot]));

  assert_zero_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (reqPulse == '0) |=> (doneStatus != 2'd0) || !pwmOut[doneSlot]);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cntRunning && !reqValid |=> $stable(pwmOut));

  logic unusedChk;
  assign unusedChk = ^{prescSel, reqId};
endmodule

bind pwm_share_top pwm_share_chk #(
  .NUM_CH(NUM_CH), .ID_W(ID_W), .REQ_W(REQ_W), .CNT_W(CNT_W),
  .FLAG_W(FLAG_W), .PS_W(PS_W), .SIW(SIW)
) u_chk (
  .clk(clk), .rstN(rstN), .prescSel(prescSel), .reqValid(reqValid),
  .reqId(reqId), .reqPeriod(reqPeriod), .reqPulse(reqPulse),
  .reqFlags(reqFlags), .doneValid(doneValid), .doneStatus(doneStatus),
  .doneSlot(doneSlot), .pwmOut(pwmOut), .cntRunning(cntRunning),
  .boundIds(boundIds)
);

// File: tb/sim_pwm_share_top.sv
module sim_pwm_share_top;
  localparam int NUM_CH = 3;
  localparam int ID_W   = 5;
  localparam int REQ_W  = 20;
  localparam int CNT_W  = 16;
  localparam int FLAG_W = 2;
  localparam int PS_W   = 3;
  localparam int SIW    = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                   rstN;
  logic [PS_W-1:0]        prescSel;
  logic                   reqValid;
  logic [ID_W-1:0]        reqId;
  logic [REQ_W-1:0]       reqPeriod, reqPulse;
  logic [FLAG_W-1:0]      reqFlags;
  logic                   doneValid;
  logic [1:0]             doneStatus;
  logic [SIW-1:0]         doneSlot;
  logic [NUM_CH-1:0]      pwmOut;
  logic                   cntRunning;
  logic [NUM_CH*ID_W-1:0] boundIds;

  int total = 0;
  int bad   = 0;

  pwm_share_top u0 (
    .clk(clk), .rstN(rstN), .prescSel(prescSel), .reqValid(reqValid),
    .reqId(reqId), .reqPeriod(reqPeriod), .reqPulse(reqPulse),
    .reqFlags(reqFlags), .doneValid(doneValid), .doneStatus(doneStatus),
    .doneSlot(doneSlot), .pwmOut(pwmOut), .cntRunning(cntRunning),
    .boundIds(boundIds)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Issue one request; returns at the negedge after the completion edge.
  task automatic send(input int id, input int period, input int pulse, input int flags,
                      output int status, output int slot);
    @(negedge clk);
    reqValid  = 1'b1;
    reqId     = ID_W'(id);
    reqPeriod = REQ_W'(period);
    reqPulse  = REQ_W'(pulse);
    reqFlags  = FLAG_W'(flags);
    @(negedge clk);
    reqValid = 1'b0;
    check("R10 done pulse", longint'(doneValid), 1);
    status = int'(doneStatus);
    slot   = int'(doneSlot);
  endtask

  task automatic countHigh(input int s, input int len, output int n);
    n = 0;
    for (int k = 0; k < len; k++) begin
      if (pwmOut[s]) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int st, sl, n;
    int pers[3] = '{4, 5, 7};
    rstN = 1'b0; prescSel = '0; reqValid = 1'b0; reqId = '0;
    reqPeriod = '0; reqPulse = '0; reqFlags = '0;
    repeat (3) @(negedge clk);
    check("R11 outputs low", longint'(pwmOut), 0);
    check("R11 not running", longint'(cntRunning), 0);
    check("R11 no done", longint'(doneValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 single done", longint'(doneValid), 0);

    send(1, 10, 3, 1, st, sl);
    check("R1 flags status", st, 3);
    check("R1 still stopped", longint'(cntRunning), 0);
    check("R1 no binding", longint'(boundIds), 0);

    send(1, 70000, 3, 0, st, sl);
    check("R2 long period", st, 1);

    // Sweep prescaler, period and pulse on id 2 (R5 R6 R9, R4 reuse, R3 same id)
    for (int p = 0; p < 3; p++) begin
      prescSel = PS_W'(p);
      for (int q = 0; q < 3; q++) begin
        for (int pl = 1; pl < pers[q]; pl++) begin
          send(2, pers[q], pl, 0, st, sl);
          check("R3 R5 accept", st, 0);
          check("R4 slot 2", sl, 2);
          check("R5 running", longint'(cntRunning), 1);
          countHigh(2, (2 * pers[q]) << p, n);
          check("R6 R9 high time", n, (2 * pl) << p);
        end
      end
    end
    prescSel = '0;

    send(9, 8, 3, 0, st, sl);
    check("R3 period clash", st, 1);
    check("R10 reject keeps slot2 id", longint'(boundIds[2*ID_W +: ID_W]), 2);
    send(9, 8, 0, 0, st, sl);
    check("R3 static exempt", st, 0);
    check("R4 highest free", sl, 1);
    check("R7 static low", longint'(pwmOut[1]), 0);
    send(9, 8, 8, 0, st, sl);
    check("R4 reuse id", sl, 1);
    check("R7 static high", longint'(pwmOut[1]), 1);
    check("R7 counter kept", longint'(cntRunning), 1);

    send(9, 7, 2, 0, st, sl);
    check("R5 second channel", st, 0);
    countHigh(1, 14, n);
    check("R6 second channel high", n, 4);

    send(4, 7, 3, 0, st, sl);
    check("R4 last slot", sl, 0);
    send(12, 7, 1, 0, st, sl);
    check("R4 no slot", st, 2);
    check("R10 reject keeps run", longint'(cntRunning), 1);
    send(4, 7, 3, 2, st, sl);
    check("R1 flags while running", st, 3);
    check("R1 binding kept", longint'(boundIds[0 +: ID_W]), 4);

    send(4, 7, 0, 0, st, sl);
    check("R8 still running", longint'(cntRunning), 1);
    send(9, 7, 7, 0, st, sl);
    check("R8 still running 2", longint'(cntRunning), 1);
    send(2, 7, 0, 0, st, sl);
    check("R8 stopped", longint'(cntRunning), 0);
    repeat (20) @(negedge clk);
    check("R8 outputs held", longint'(pwmOut), 2);

    send(12, 65535, 0, 0, st, sl);
    check("R2 max period ok", st, 0);
    check("R4 free slot after stop", sl, 2);
    send(12, 65536, 0, 0, st, sl);
    check("R2 static too long", st, 1);
    send(12, 100, 50, 0, st, sl);
    check("R3 new period when idle", st, 0);
    check("R4 reuse slot 2", sl, 2);
    countHigh(2, 100, n);
    check("R6 long period high", n, 50);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule